// File: doc/BRIEF.md
# Masked-Write GPIO Port Bank

This block holds a set of GPIO ports behind a simple memory-mapped request bus. Each group of four ports forms a bank, and each port owns eight pins. Every port has three writable control registers: a mode register, an output-enable register and an output-data register. It also has a read-only register that returns the pad levels after synchronization. A pin is driven by its output-data bit only when its mode bit and its enable bit are both set. Otherwise the pad carries the value supplied by an alternate function, which passes straight through.

Every writable register can also be reached at a second, masked address. A write there treats the second byte of the data word as a per-pin select for the first byte. Only the selected pins change, so software can set or clear one pin in a single bus write, without a read-modify-write and without a lock. Requests are accepted every cycle. A write takes effect at the clock edge that samples it. A read returns its data, flagged by `rd_valid`, in the cycle after the request.

Top module: `gpio_mask_bank`

## Requirements
- R1: After a synchronous reset, every mode, enable and output bit is 0. `pad_mode` and `pad_oe` are all 0, `pad_out` equals `alt_out`, and reads of the control registers return 0.
- R2: The address is bank*0x80 + port*4 + register offset. The offsets are 0x00 mode, 0x10 output enable, 0x20 output data and 0x30 input. Address bits [1:0] are ignored. A plain write stores `req_wdata[7:0]` and ignores every higher bit. A read returns the register in `rd_data[7:0]` with bits [31:8] at 0.
- R3: Address bit 11 selects the masked alias of the same register. In a masked write, bit 8+n of the data enables pin n and bit n gives its new value. Pins whose enable bit is 0 keep their value, so a zero mask changes nothing.
- R4: The input register holds the pad levels after a two-flop synchronizer. A read that is sampled at the second clock edge after a pad change still returns the old level. A read sampled one edge later returns the new level. Writes to offset 0x30, plain or masked, have no effect.
- R5: For each pin, `pad_mode` equals the mode bit and `pad_oe` equals mode AND enable. `pad_out` is the output-data bit when `pad_oe` is 1, and the `alt_out` bit, combinationally, when it is 0.
- R6: `rd_valid` rises in the cycle after each read request, for one cycle per request. Write requests and idle cycles never raise it.
- R7: A request is unmapped when its bank field (address bits [10:7]) is not below NUM_BANKS, or when its register field (bits [6:4]) is 4 to 7. An unmapped write changes nothing, and an unmapped read returns 0. A read of a masked alias also returns 0.
- R8: A read issued in the cycle right after a write to the same register returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data (mask in bits 15:8 for masked writes) |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| pad_in | input | 64 | Asynchronous pad levels, pin 8*port+bit |
| alt_out | input | 64 | Alternate-function output for each pin |
| pad_out | output | 64 | Value driven toward each pad |
| pad_oe | output | 64 | Pad output enable |
| pad_mode | output | 64 | 1 = pin under GPIO control |

## Verification
Two things can land on a pin in the same cycle: a bus write that changes its mode or enable, and a change of its alternate-function value. Because the pad mux is combinational on `alt_out`, the pad must follow the new alternate value in the cycle of the write and switch to the output-data bit only after the clock edge. The bench provokes this with a masked mode write that is issued together with a toggle of the same pin's `alt_out`. A second case pairs a pad transition with an input read one edge too early and one edge late. A behavioural model predicts every pad and read output on every clock, through directed sequences and a randomized phase that also covers unmapped and masked addresses.

// File: rtl/gpio_mb_pkg.sv
`timescale 1ns/1ps
package gpio_mb_pkg;
  // address field layout (behaviour depends on these positions)
  localparam int unsigned ADDR_W         = 12;
  localparam int unsigned ALIAS_BIT      = 11;
  localparam int unsigned BANK_LSB       = 7;
  localparam int unsigned BANK_W         = 4;
  localparam int unsigned KIND_LSB       = 4;
  localparam int unsigned KIND_W         = 3;
  localparam int unsigned PORT_LSB       = 2;
  localparam int unsigned PSEL_W         = 2;
  localparam int unsigned PORTS_PER_BANK = 4;

  typedef enum logic [1:0] {
    RK_MODE = 2'd0,
    RK_OE   = 2'd1,
    RK_OUT  = 2'd2,
    RK_IN   = 2'd3
  } reg_kind_e;

  typedef struct packed {
    logic                     hit;
    logic                     is_mask;
    reg_kind_e                kind;
    logic [BANK_W+PSEL_W-1:0] port_flat;
  } req_dec_t;
endpackage

// File: rtl/gpio_mb_decode.sv
`timescale 1ns/1ps
module gpio_mb_decode
  import gpio_mb_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output req_dec_t          dec
);
  logic [BANK_W-1:0] bank;
  logic [KIND_W-1:0] kind_raw;
  logic              unused_lsb;

  assign unused_lsb = ^addr[PORT_LSB-1:0];

  always_comb begin
    bank          = addr[BANK_LSB +: BANK_W];
    kind_raw      = addr[KIND_LSB +: KIND_W];
    dec.hit       = (32'(bank) < NUM_BANKS) && !kind_raw[KIND_W-1];
    dec.is_mask   = addr[ALIAS_BIT];
    dec.kind      = reg_kind_e'(kind_raw[1:0]);
    dec.port_flat = {bank, addr[PORT_LSB +: PSEL_W]};
  end
endmodule

// File: rtl/gpio_mb_sync.sv
`timescale 1ns/1ps
module gpio_mb_sync #(
  parameter int unsigned WIDTH  = 64,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= din;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_mb_port.sv
`timescale 1ns/1ps
module gpio_mb_port
  import gpio_mb_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              is_mask,
  input  reg_kind_e         kind,
  input  logic [2*PINS-1:0] wdata,
  input  logic [PINS-1:0]   alt_out,
  output logic [PINS-1:0]   mode_q,
  output logic [PINS-1:0]   oe_q,
  output logic [PINS-1:0]   out_q,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe
);
  logic [PINS-1:0] wval;
  logic [PINS-1:0] wsel;

  // a plain write selects every pin; the masked alias uses the upper byte
  assign wval = wdata[PINS-1:0];
  assign wsel = is_mask ? wdata[2*PINS-1:PINS] : '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      oe_q   <= '0;
      out_q  <= '0;
    end else if (wr_en) begin
      unique case (kind)
        RK_MODE: mode_q <= (mode_q & ~wsel) | (wval & wsel);
        RK_OE:   oe_q   <= (oe_q   & ~wsel) | (wval & wsel);
        RK_OUT:  out_q  <= (out_q  & ~wsel) | (wval & wsel);
        RK_IN:   ;
        default: ;
      endcase
    end
  end

  generate
    for (genvar b = 0; b < PINS; b++) begin : g_pin
      assign pad_oe[b]  = mode_q[b] & oe_q[b];
      assign pad_out[b] = pad_oe[b] ? out_q[b] : alt_out[b];
    end
  endgenerate
endmodule

// File: rtl/gpio_mask_bank.sv
`timescale 1ns/1ps
module gpio_mask_bank
  import gpio_mb_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned PORT_PINS = 8,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned NPORTS   = NUM_BANKS * PORTS_PER_BANK,
  localparam int unsigned NPINS    = NPORTS * PORT_PINS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NPINS-1:0]  pad_in,
  input  logic [NPINS-1:0]  alt_out,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_mode
);
  localparam int unsigned PIDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;

  req_dec_t             dec;
  logic [PIDX_W-1:0]    sel_idx;
  logic                 wr_go;
  logic                 rd_go;
  logic [PORT_PINS-1:0] mode_all [NPORTS];
  logic [PORT_PINS-1:0] oe_all   [NPORTS];
  logic [PORT_PINS-1:0] out_all  [NPORTS];
  logic [PORT_PINS-1:0] in_all   [NPORTS];
  logic [NPINS-1:0]     in_sync;
  logic [PORT_PINS-1:0] rd_byte;
  logic                 unused_hi;

  assign unused_hi = ^{req_wdata[DATA_W-1:2*PORT_PINS], dec.port_flat};

  gpio_mb_decode #(.NUM_BANKS(NUM_BANKS)) dec_i (
    .addr (req_addr),
    .dec  (dec)
  );

  assign sel_idx = dec.port_flat[PIDX_W-1:0];
  assign wr_go   = req_valid &  req_write & dec.hit;
  assign rd_go   = req_valid & ~req_write;

  gpio_mb_sync #(.WIDTH(NPINS), .STAGES(2)) sync_i (
    .clk  (clk),
    .rst  (rst),
    .din  (pad_in),
    .dout (in_sync)
  );

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
      logic port_wr;
      assign port_wr   = wr_go && (sel_idx == PIDX_W'(p));
      assign in_all[p] = in_sync[p*PORT_PINS +: PORT_PINS];
      assign pad_mode[p*PORT_PINS +: PORT_PINS] = mode_all[p];

      gpio_mb_port #(.PINS(PORT_PINS)) port_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (port_wr),
        .is_mask (dec.is_mask),
        .kind    (dec.kind),
        .wdata   (req_wdata[2*PORT_PINS-1:0]),
        .alt_out (alt_out[p*PORT_PINS +: PORT_PINS]),
        .mode_q  (mode_all[p]),
        .oe_q    (oe_all[p]),
        .out_q   (out_all[p]),
        .pad_out (pad_out[p*PORT_PINS +: PORT_PINS]),
        .pad_oe  (pad_oe[p*PORT_PINS +: PORT_PINS])
      );
    end
  endgenerate

  always_comb begin
    rd_byte = '0;
    if (dec.hit && !dec.is_mask) begin
      unique case (dec.kind)
        RK_MODE: rd_byte = mode_all[sel_idx];
        RK_OE:   rd_byte = oe_all[sel_idx];
        RK_OUT:  rd_byte = out_all[sel_idx];
        RK_IN:   rd_byte = in_all[sel_idx];
        default: rd_byte = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_go;
      rd_data  <= rd_go ? DATA_W'(rd_byte) : '0;
    end
  end
endmodule

// File: rtl/gpio_mb_checker.sv
`timescale 1ns/1ps
module gpio_mb_checker
  import gpio_mb_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned PORT_PINS = 8,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned NPINS    = NUM_BANKS * PORTS_PER_BANK * PORT_PINS
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [NPINS-1:0]  alt_out,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  pad_mode
);
  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (pad_mode == '0 && pad_oe == '0 && !rd_valid));

  // R6
  a_r6_read_valid: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rd_valid);
  a_r6_no_stray_valid: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rd_valid);

  // R2
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_data[DATA_W-1:PORT_PINS] == '0));

  // R7
  a_r7_gap_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_addr[KIND_LSB+KIND_W-1]) |=> (rd_data == '0));
  a_r7_alias_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_addr[ALIAS_BIT]) |=> (rd_data == '0));

  // R3
  a_r3_empty_mask: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr[ALIAS_BIT] &&
     req_wdata[2*PORT_PINS-1:PORT_PINS] == '0) |=> ($stable(pad_mode) && $stable(pad_oe)));

  // R4
  a_r4_input_readonly: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_addr[KIND_LSB +: KIND_W] == 3'd3)
      |=> ($stable(pad_mode) && $stable(pad_oe)));

  // R5
  a_r5_oe_needs_mode: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe & ~pad_mode) == '0));
  a_r5_alt_passthrough: assert property (@(posedge clk) disable iff (rst)
    (((pad_out ^ alt_out) & ~pad_oe) == '0));
endmodule

bind gpio_mask_bank gpio_mb_checker #(
  .NUM_BANKS (NUM_BANKS),
  .PORT_PINS (PORT_PINS),
  .DATA_W    (DATA_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .alt_out   (alt_out),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .pad_mode  (pad_mode)
);

// File: tb/gpio_mask_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_mask_bank_tb_top;
  localparam int NB = 2;
  localparam int NP = NB * 4;
  localparam int NPIN = NP * 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic            req_write = 1'b0;
  logic [11:0]     req_addr = '0;
  logic [31:0]     req_wdata = '0;
  logic            rd_valid;
  logic [31:0]     rd_data;
  logic [NPIN-1:0] pad_in = '0;
  logic [NPIN-1:0] alt_out = 64'h0123_4567_89AB_CDEF;
  logic [NPIN-1:0] pad_out, pad_oe, pad_mode;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit live = 0;

  always #2 clk = ~clk;

  gpio_mask_bank dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .pad_in(pad_in), .alt_out(alt_out),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_mode(pad_mode)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0]      m_mode [NP];
  logic [7:0]      m_oe   [NP];
  logic [7:0]      m_out  [NP];
  logic [NPIN-1:0] m_hist1, m_hist2;
  logic            m_rv;
  logic [31:0]     m_rd;

  always @(posedge clk) begin
    int bank, kind, idx;
    bit ok, msk;
    logic [7:0] nv, sel;
    if (rst) begin
      for (int i = 0; i < NP; i++) begin
        m_mode[i] = 0; m_oe[i] = 0; m_out[i] = 0;
      end
      m_hist1 = 0; m_hist2 = 0; m_rv = 0; m_rd = 0;
      live = 1;
    end else begin
      bank = int'(req_addr[10:7]);
      kind = int'(req_addr[6:4]);
      idx  = bank * 4 + int'(req_addr[3:2]);
      msk  = req_addr[11];
      ok   = (bank < NB) && (kind < 4);
      m_rv = req_valid && !req_write;
      m_rd = 0;
      if (m_rv && ok && !msk) begin
        case (kind)
          0: m_rd[7:0] = m_mode[idx];
          1: m_rd[7:0] = m_oe[idx];
          2: m_rd[7:0] = m_out[idx];
          default: m_rd[7:0] = m_hist2[idx*8 +: 8];
        endcase
      end
      if (req_valid && req_write && ok && kind != 3) begin
        nv  = req_wdata[7:0];
        sel = msk ? req_wdata[15:8] : 8'hFF;
        for (int b = 0; b < 8; b++) begin
          if (sel[b]) begin
            if (kind == 0) m_mode[idx][b] = nv[b];
            else if (kind == 1) m_oe[idx][b] = nv[b];
            else m_out[idx][b] = nv[b];
          end
        end
      end
      m_hist2 = m_hist1;
      m_hist1 = pad_in;
    end
  end

  always @(negedge clk) begin
    logic [NPIN-1:0] e_mode, e_oe, e_out;
    if (live && !done) begin
      for (int p = 0; p < NP; p++) begin
        for (int b = 0; b < 8; b++) begin
          e_mode[p*8+b] = m_mode[p][b];
          e_oe[p*8+b]   = m_mode[p][b] & m_oe[p][b];
          e_out[p*8+b]  = e_oe[p*8+b] ? m_out[p][b] : alt_out[p*8+b];
        end
      end
      chk("R5 pad_mode", pad_mode, e_mode);
      chk("R5 pad_oe", pad_oe, e_oe);
      chk("R5 pad_out", pad_out, e_out);
      chk("R6 rd_valid", 64'(rd_valid), 64'(m_rv));
      chk("R2 rd_data", 64'(rd_data), 64'(m_rd));
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
  endtask

  task automatic wr_alt(input logic [11:0] a, input logic [31:0] d, input logic [NPIN-1:0] alt);
    @(negedge clk); #1;
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; alt_out = alt;
  endtask

  task automatic rd(input logic [11:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); #1;
    req_valid = 1; req_write = 0; req_addr = a; req_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    chk({tag, " valid"}, 64'(rd_valid), 64'd1);
    chk(tag, 64'(rd_data), 64'(exp));
    #1 req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk); #1;
      req_valid = 0;
    end
  endtask

  task automatic set_pad(input logic [NPIN-1:0] v);
    @(negedge clk); #1;
    req_valid = 0; pad_in = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R6 watchdog got=timeout exp=finish");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rst = 0;

    // R1 reset state
    rd(12'h000, 8'h00, "R1 mode after reset");
    rd(12'h010, 8'h00, "R1 enable after reset");
    rd(12'h020, 8'h00, "R1 output after reset");
    chk("R1 pad_out follows alt", pad_out, alt_out);
    chk("R1 pad_oe zero", pad_oe, 64'd0);

    // R2 plain writes and readback
    wr(12'h000, 32'h0000_00A5);
    wr(12'h010, 32'h0000_000F);
    wr(12'h020, 32'h0000_003C);
    rd(12'h000, 8'hA5, "R2 mode readback");
    rd(12'h010, 8'h0F, "R2 enable readback");
    rd(12'h020, 8'h3C, "R2 output readback");
    chk("R5 port0 pad_oe", 64'(pad_oe[7:0]), 64'h05);
    chk("R5 port0 pad_out", 64'(pad_out[7:0]), 64'hEE);
    wr(12'h088, 32'h0000_00FF);
    rd(12'h088, 8'hFF, "R2 bank1 port2 mode");
    rd(12'h008, 8'h00, "R2 bank0 port2 separate");
    rd(12'h003, 8'hA5, "R2 low address bits ignored");

    // R3 masked alias
    wr(12'h820, 32'h0000_0301);
    rd(12'h020, 8'h3D, "R3 masked output update");
    wr(12'h820, 32'hFFFF_0080);
    rd(12'h020, 8'h3D, "R3 zero mask keeps");
    wr(12'h010, 32'hABCD_FF12);
    rd(12'h010, 8'h12, "R2 upper data ignored");
    wr(12'h800, 32'h0000_F00F);
    rd(12'h000, 8'h05, "R3 masked mode update");

    // R7 unmapped and alias reads
    rd(12'h820, 8'h00, "R7 alias read zero");
    wr(12'h100, 32'h0000_00FF);
    rd(12'h100, 8'h00, "R7 bank out of range read");
    wr(12'h040, 32'h0000_00FF);
    rd(12'h040, 8'h00, "R7 gap offset read");
    rd(12'h000, 8'h05, "R7 port0 mode untouched");
    rd(12'h088, 8'hFF, "R7 bank1 mode untouched");

    // R4 input register
    set_pad(64'hC300_0000_0000_005A);
    idle(1);
    rd(12'h030, 8'h5A, "R4 input port0");
    rd(12'h0BC, 8'hC3, "R4 input bank1 port3");
    wr(12'h030, 32'h0000_00FF);
    wr(12'h830, 32'h0000_FFFF);
    rd(12'h030, 8'h5A, "R4 input read-only");
    rd(12'h000, 8'h05, "R4 write to input leaves mode");
    set_pad(64'hC300_0000_0000_0011);
    rd(12'h030, 8'h5A, "R4 sync latency old value");
    rd(12'h030, 8'h11, "R4 sync latency new value");

    // R6 no valid on write, R8 back-to-back
    wr(12'h024, 32'h0000_0077);
    @(negedge clk);
    chk("R6 no valid after write", 64'(rd_valid), 64'd0);
    wr(12'h024, 32'h0000_0077);
    rd(12'h024, 8'h77, "R8 read right after write");
    wr(12'h824, 32'h0000_0E00);
    rd(12'h024, 8'h71, "R8 read right after masked write");

    // collision: mode change together with alt_out toggle on pin 8
    wr(12'h014, 32'h0000_00FF);
    wr_alt(12'h804, 32'h0000_0101, alt_out ^ 64'h100);
    idle(1);
    chk("R5 collision pad_out pin8", 64'(pad_out[8]), 64'd1);
    chk("R5 collision pad_oe pin8", 64'(pad_oe[8]), 64'd1);

    // randomized phase, judged by the model every clock
    for (int n = 0; n < 400; n++) begin
      @(negedge clk); #1;
      req_valid = 1'($urandom % 2);
      req_write = 1'($urandom % 2);
      req_addr  = {1'($urandom % 2), 4'($urandom % 3), 3'($urandom % 5),
                   2'($urandom % 4), 2'($urandom % 4)};
      req_wdata = $urandom;
      if (n % 3 == 0) pad_in = {$urandom, $urandom};
      if (n % 5 == 0) alt_out = {$urandom, $urandom};
    end
    idle(4);
    finish_up();
  end
endmodule